// File: doc/BRIEF.md
# Reset Cause and Control Register Block

This block is the software-visible register set of a system reset controller. It records in sticky bits which source produced the latest chip reset. It holds keyed mask codes that stop chosen sources from resetting the chip, and an enable for the core lockup source. It also provides a self-clearing core reset command, a level-held peripheral reset, and general-purpose words that keep their contents through a warm reset. A separate sequencer consumes the request outputs and returns a done pulse once a core reset has finished.

Two reset inputs drive the block. A cold (power-on) reset clears everything, including the general-purpose words, and leaves only the power-on cause bit set. A warm reset, which the sequencer applies after a request, returns the control fields to their defaults. It keeps the cause bits, the warm-boot bit and the general-purpose words. Each reset input is asserted asynchronously and released through a two-stage synchronizer. Source events, the temperature interrupt and the done pulse are expected to be synchronous to `clk` already.

Register map (word addresses): 0 is the control register, 1 is the cause register, and 2 up to 2+N_GPR-1 are the general-purpose words. A read of any other address returns zero. Reads are combinational from the address. Writes take effect at the clock edge where `wr_en` is high.

Top module: `rstctl_regs`

## Requirements
- R1: After a cold reset the cause register reads 0x01 (bit 0 = power-on) and every general-purpose word reads 0. The control register reads 0x12A: watchdog key [3:0] = 0xA, temperature key [7:4] = 0x2, lockup enable [8] = 1, core command [9] = 0, peripheral reset [10] = 0. All outputs are low.
- R2: A source event that is not masked sets its cause bit and raises `sys_rst_req`, both one clock after the event cycle. Source index i maps to cause bit i+1: 0 watchdog, 1 temperature, 2 lockup, 3 software request, 4 debug-port generated, 5 debug-port software.
- R3: Writing the cause register clears each of bits [6:0] where the written bit is 1. A written 0 leaves the bit unchanged.
- R4: Cause bit 7 is the warm-boot indication and is plain read/write. A write that changes it clears no cause bit whose written value is 0.
- R5: Cause bit 2 (temperature) cannot be cleared while `temp_irq` is high.
- R6: With watchdog key 0x5, a watchdog event raises no request and sets no cause bit. It sets `wdog_hold` instead, which stays high until the next warm or cold reset, even if the key is changed.
- R7: Temperature key 0x5 masks the temperature source. A key value other than 0x5 in either key field leaves that source unmasked.
- R8: With lockup enable 0, a lockup event raises no request and sets no cause bit.
- R9: Writing 1 to control bit 9 raises `core_rst_req` and makes bit 9 read 1 from the next cycle. Both return to 0 one cycle after a `core_rst_done` pulse. Writing 0 to bit 9 has no effect.
- R10: Control bit 10 drives `periph_rst` and holds its value until software writes it again. It does not self-clear.
- R11: A warm reset restores the control register to 0x12A and clears `periph_rst`, `core_rst_req` and `sys_rst_req`. It keeps the cause register and the general-purpose words.
- R12: Cause bits stay set over any number of cycles without a cause-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Cold reset, active low, asynchronous assert |
| rst_n | input | 1 | Warm reset, active low, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| src_event | input | 6 | Per-source reset events, one bit per source |
| temp_irq | input | 1 | Temperature interrupt still pending |
| core_rst_done | input | 1 | Sequencer pulse: core reset finished |
| sys_rst_req | output | 1 | Chip reset request to the sequencer |
| core_rst_req | output | 1 | Core-only reset request (command bit) |
| periph_rst | output | 1 | Level-held peripheral reset |
| wdog_hold | output | 1 | Masked watchdog event seen since last reset |

## Verification
The bench builds the block with its defaults: 32-bit data, a 4-bit address and four general-purpose words. With these values the first and the last general-purpose word can both be checked across a warm reset, and a cold reset can be checked to clear them. Because every key is a 4-bit field, the bench can drive the masking code, both unmasking defaults and the off-code values 0x0 and 0xF into each key. It then observes the request and the cause bits for each.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int NUM_SRC = 6;
  localparam int CAUSE_W = NUM_SRC + 2;

  // source indices on src_event
  localparam int SRC_WDOG    = 0;
  localparam int SRC_TEMP    = 1;
  localparam int SRC_LOCKUP  = 2;
  localparam int SRC_SWREQ   = 3;
  localparam int SRC_DBG_HW  = 4;
  localparam int SRC_DBG_SW  = 5;

  // cause register layout: power-on at 0, source i at i+1, warm boot on top
  localparam int CAUSE_POR   = 0;
  localparam int CAUSE_WBOOT = NUM_SRC + 1;

  localparam logic [3:0] WDOG_KEY_OPEN = 4'hA;
  localparam logic [3:0] TEMP_KEY_OPEN = 4'h2;
  localparam logic [3:0] KEY_SHUT      = 4'h5;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_CAUSE = 1;
  localparam int ADDR_GPR0  = 2;

  typedef struct packed {
    logic       periph;
    logic       core_cmd;
    logic       lockup_en;
    logic [3:0] temp_key;
    logic [3:0] wdog_key;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_DEFAULT = '{periph: 1'b0, core_cmd: 1'b0, lockup_en: 1'b1,
                                     temp_key: TEMP_KEY_OPEN, wdog_key: WDOG_KEY_OPEN};

  function automatic logic key_is_shut(input logic [3:0] key);
    return key == KEY_SHUT;
  endfunction

endpackage

// File: rtl/rstctl_rsync.sv
module rstctl_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause
  import rstctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_cause,
  input  logic [CAUSE_W-1:0] wdata,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               temp_irq,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [NUM_SRC:0]   clr_mask;

  always_comb begin
    clr_mask = '0;
    if (wr_cause) clr_mask = wdata[NUM_SRC:0];
    if (temp_irq) clr_mask[SRC_TEMP+1] = 1'b0;
    cause_d = cause_q;
    cause_d[NUM_SRC:0] = cause_q[NUM_SRC:0] & ~clr_mask;
    if (wr_cause) cause_d[CAUSE_WBOOT] = wdata[CAUSE_WBOOT];
    cause_d[NUM_SRC:1] = cause_d[NUM_SRC:1] | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_W'(1) << CAUSE_POR;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rstctl_ctrl.sv
module rstctl_ctrl
  import rstctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  ctrl_t wdata,
  input  logic  core_done,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.wdog_key  = wdata.wdog_key;
      ctrl_d.temp_key  = wdata.temp_key;
      ctrl_d.lockup_en = wdata.lockup_en;
      ctrl_d.periph    = wdata.periph;
    end
    if (core_done) ctrl_d.core_cmd = 1'b0;
    if (wr_ctrl && wdata.core_cmd) ctrl_d.core_cmd = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_DEFAULT;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rstctl_gpr.sv
module rstctl_gpr #(
  parameter int N_GPR  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_GPR > 1) ? $clog2(N_GPR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] gpr_q [N_GPR];

  for (genvar g = 0; g < N_GPR; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_d;
    assign hit = wr_en && (idx == IDX_W'(g));
    always_comb begin
      word_d = gpr_q[g];
      if (hit) word_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gpr_q[g] <= '0;
      else        gpr_q[g] <= word_d;
    end
  end

  assign rdata = gpr_q[idx];
endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int N_GPR  = 4
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic               temp_irq,
  input  logic               core_rst_done,
  output logic               sys_rst_req,
  output logic               core_rst_req,
  output logic               periph_rst,
  output logic               wdog_hold
);
  localparam int GPR_IDX_W = (N_GPR > 1) ? $clog2(N_GPR) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(ADDR_CAUSE);
  localparam logic [ADDR_W-1:0] A_GPR0  = ADDR_W'(ADDR_GPR0);
  localparam logic [ADDR_W-1:0] A_GPREND = ADDR_W'(ADDR_GPR0 + N_GPR);

  logic por_s_n, warm_s_n;

  rstctl_rsync #(.STAGES(2)) u_sync_cold (.clk(clk), .arst_n(por_n), .srst_n(por_s_n));
  rstctl_rsync #(.STAGES(2)) u_sync_warm (.clk(clk), .arst_n(por_n & rst_n), .srst_n(warm_s_n));

  // address decode
  logic                 sel_ctrl, sel_cause, sel_gpr;
  logic [GPR_IDX_W-1:0] gpr_idx;

  assign sel_ctrl  = (addr == A_CTRL);
  assign sel_cause = (addr == A_CAUSE);
  assign sel_gpr   = (addr >= A_GPR0) && (addr < A_GPREND);
  assign gpr_idx   = GPR_IDX_W'(addr - A_GPR0);

  // control fields
  ctrl_t ctrl_q;
  logic  wdog_masked, temp_masked;

  rstctl_ctrl u_ctrl (
    .clk(clk), .rst_n(warm_s_n), .wr_ctrl(wr_en && sel_ctrl),
    .wdata(ctrl_t'(wdata[CTRL_W-1:0])), .core_done(core_rst_done), .ctrl_o(ctrl_q)
  );

  assign wdog_masked = key_is_shut(ctrl_q.wdog_key);
  assign temp_masked = key_is_shut(ctrl_q.temp_key);

  // source gating
  logic [NUM_SRC-1:0] eff_evt;
  always_comb begin
    eff_evt = src_event;
    eff_evt[SRC_WDOG]   = src_event[SRC_WDOG]   & ~wdog_masked;
    eff_evt[SRC_TEMP]   = src_event[SRC_TEMP]   & ~temp_masked;
    eff_evt[SRC_LOCKUP] = src_event[SRC_LOCKUP] & ctrl_q.lockup_en;
  end

  // cause record, survives warm reset
  logic [CAUSE_W-1:0] cause_q;

  rstctl_cause u_cause (
    .clk(clk), .rst_n(por_s_n), .wr_cause(wr_en && sel_cause),
    .wdata(wdata[CAUSE_W-1:0]), .set_vec(eff_evt), .temp_irq(temp_irq), .cause_o(cause_q)
  );

  // request and watchdog hold
  logic req_q, req_d, hold_q, hold_d;

  always_comb begin
    req_d  = |eff_evt;
    hold_d = hold_q | (src_event[SRC_WDOG] & wdog_masked);
  end

  always_ff @(posedge clk or negedge warm_s_n) begin
    if (!warm_s_n) begin
      req_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  // retained words
  logic [DATA_W-1:0] gpr_rd;

  rstctl_gpr #(.N_GPR(N_GPR), .DATA_W(DATA_W)) u_gpr (
    .clk(clk), .rst_n(por_s_n), .wr_en(wr_en && sel_gpr),
    .idx(gpr_idx), .wdata(wdata), .rdata(gpr_rd)
  );

  // read mux
  always_comb begin
    rdata = '0;
    if (sel_ctrl)       rdata = DATA_W'(ctrl_q);
    else if (sel_cause) rdata = DATA_W'(cause_q);
    else if (sel_gpr)   rdata = gpr_rd;
  end

  assign sys_rst_req  = req_q;
  assign core_rst_req = ctrl_q.core_cmd;
  assign periph_rst   = ctrl_q.periph;
  assign wdog_hold    = hold_q;
endmodule

// File: rtl/rstctl_regs_chk.sv
module rstctl_regs_chk
  import rstctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               cold_n,
  input logic               warm_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] src_event,
  input logic               temp_irq,
  input logic               core_rst_done,
  input logic               sys_rst_req,
  input logic               core_rst_req,
  input logic               periph_rst,
  input logic               wdog_hold,
  input logic               wdog_masked,
  input logic [CAUSE_W-1:0] cause_q
);
  logic wr_cause, wr_ctrl;
  assign wr_cause = wr_en && (addr == ADDR_W'(ADDR_CAUSE));
  assign wr_ctrl  = wr_en && (addr == ADDR_W'(ADDR_CTRL));

  a_r2_swreq_request: assert property (@(posedge clk) disable iff (!warm_n)
    src_event[SRC_SWREQ] |=> sys_rst_req);

  a_r2_swreq_cause: assert property (@(posedge clk) disable iff (!cold_n || !warm_n)
    src_event[SRC_SWREQ] |=> cause_q[SRC_SWREQ+1]);

  a_r12_cause_sticky: assert property (@(posedge clk) disable iff (!cold_n)
    !wr_cause |=> ((cause_q[NUM_SRC:0] & $past(cause_q[NUM_SRC:0])) == $past(cause_q[NUM_SRC:0])));

  a_r4_wboot_stable: assert property (@(posedge clk) disable iff (!cold_n)
    !wr_cause |=> $stable(cause_q[CAUSE_WBOOT]));

  a_r5_temp_kept: assert property (@(posedge clk) disable iff (!cold_n)
    (cause_q[SRC_TEMP+1] && temp_irq) |=> cause_q[SRC_TEMP+1]);

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!warm_n)
    (wdog_masked && src_event == NUM_SRC'(1 << SRC_WDOG)) |=> !sys_rst_req);

  a_r6_hold_sticky: assert property (@(posedge clk) disable iff (!warm_n)
    wdog_hold |=> wdog_hold);

  a_r9_core_start: assert property (@(posedge clk) disable iff (!warm_n)
    (wr_ctrl && wdata[9]) |=> core_rst_req);

  a_r9_core_finish: assert property (@(posedge clk) disable iff (!warm_n)
    (core_rst_req && core_rst_done && !(wr_ctrl && wdata[9])) |=> !core_rst_req);

  a_r10_periph_level: assert property (@(posedge clk) disable iff (!warm_n)
    !wr_ctrl |=> $stable(periph_rst));
endmodule

bind rstctl_regs rstctl_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .cold_n(por_s_n), .warm_n(warm_s_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .src_event(src_event), .temp_irq(temp_irq),
  .core_rst_done(core_rst_done), .sys_rst_req(sys_rst_req),
  .core_rst_req(core_rst_req), .periph_rst(periph_rst), .wdog_hold(wdog_hold),
  .wdog_masked(wdog_masked), .cause_q(cause_q)
);

// File: tb/rstctl_regs_test.sv
module rstctl_regs_test;
  logic        clk = 1'b0;
  logic        por_n, rst_n, wr_en, temp_irq, core_rst_done;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [5:0]  src_event;
  logic        sys_rst_req, core_rst_req, periph_rst, wdog_hold;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rstctl_regs uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_event(src_event), .temp_irq(temp_irq),
    .core_rst_done(core_rst_done), .sys_rst_req(sys_rst_req),
    .core_rst_req(core_rst_req), .periph_rst(periph_rst), .wdog_hold(wdog_hold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src_event = 6'(1 << idx);
    @(negedge clk);
    src_event = '0;
  endtask

  task automatic warm_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cold_reset();
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(4'd1, d); chk("R1 cause after cold reset", d, 32'h01);
    rd(4'd0, d); chk("R1 control defaults", d, 32'h12A);
    rd(4'd2, d); chk("R1 first word cleared", d, 32'h0);
    rd(4'd5, d); chk("R1 last word cleared", d, 32'h0);
    chk("R1 outputs low", {28'h0, sys_rst_req, core_rst_req, periph_rst, wdog_hold}, 32'h0);
  endtask

  task automatic t_cause_w1c();
    logic [31:0] d;
    pulse(4);
    chk("R2 request after debug-port event", {31'h0, sys_rst_req}, 32'h1);
    rd(4'd1, d); chk("R2 debug-port cause bit 5", d, 32'h21);
    repeat (6) @(negedge clk);
    rd(4'd1, d); chk("R12 cause stays set", d, 32'h21);
    chk("R2 request is one cycle", {31'h0, sys_rst_req}, 32'h0);
    wr(4'd1, 32'h0);
    rd(4'd1, d); chk("R3 zero write keeps bits", d, 32'h21);
    wr(4'd1, 32'h20);
    rd(4'd1, d); chk("R3 clear bit 5 only", d, 32'h01);
    wr(4'd1, 32'h01);
    rd(4'd1, d); chk("R3 clear power-on bit", d, 32'h00);
  endtask

  task automatic t_warm_boot();
    logic [31:0] d;
    pulse(3);
    rd(4'd1, d); chk("R2 software request cause bit 4", d, 32'h10);
    wr(4'd1, 32'h80);
    rd(4'd1, d); chk("R4 warm-boot set keeps cause", d, 32'h90);
    wr(4'd1, 32'h00);
    rd(4'd1, d); chk("R4 warm-boot cleared by write", d, 32'h10);
    wr(4'd1, 32'h10);
    rd(4'd1, d); chk("R3 software cause cleared", d, 32'h00);
  endtask

  task automatic t_temp_block();
    logic [31:0] d;
    temp_irq = 1'b1;
    pulse(1);
    rd(4'd1, d); chk("R2 temperature cause bit 2", d, 32'h04);
    wr(4'd1, 32'h04);
    rd(4'd1, d); chk("R5 clear refused while irq", d, 32'h04);
    temp_irq = 1'b0;
    wr(4'd1, 32'h04);
    rd(4'd1, d); chk("R5 clear after irq drops", d, 32'h00);
  endtask

  task automatic t_wdog_mask();
    logic [31:0] d;
    wr(4'd0, 32'h125);
    pulse(0);
    chk("R6 masked watchdog no request", {31'h0, sys_rst_req}, 32'h0);
    chk("R6 hold set", {31'h0, wdog_hold}, 32'h1);
    rd(4'd1, d); chk("R6 masked watchdog no cause", d, 32'h0);
    wr(4'd0, 32'h12A);
    repeat (4) @(negedge clk);
    chk("R6 hold survives unmask", {31'h0, wdog_hold}, 32'h1);
    pulse(0);
    chk("R6 unmasked watchdog requests", {31'h0, sys_rst_req}, 32'h1);
    rd(4'd1, d); chk("R6 watchdog cause bit 1", d, 32'h02);
    wr(4'd1, 32'h02);
    warm_reset();
    chk("R6 hold cleared by warm reset", {31'h0, wdog_hold}, 32'h0);
  endtask

  task automatic t_key_codes();
    logic [31:0] d;
    wr(4'd0, 32'h15F);
    pulse(1);
    chk("R7 temperature key 5 blocks", {31'h0, sys_rst_req}, 32'h0);
    rd(4'd1, d); chk("R7 no temperature cause", d, 32'h0);
    pulse(0);
    chk("R7 watchdog key F open", {31'h0, sys_rst_req}, 32'h1);
    rd(4'd1, d); chk("R7 watchdog key F cause", d, 32'h02);
    wr(4'd1, 32'h02);
    wr(4'd0, 32'h100);
    pulse(1);
    chk("R7 temperature key 0 open", {31'h0, sys_rst_req}, 32'h1);
    pulse(0);
    chk("R7 watchdog key 0 open", {31'h0, sys_rst_req}, 32'h1);
    rd(4'd1, d); chk("R7 both causes", d, 32'h06);
    wr(4'd1, 32'h06);
  endtask

  task automatic t_lockup();
    logic [31:0] d;
    wr(4'd0, 32'h02A);
    pulse(2);
    chk("R8 lockup disabled no request", {31'h0, sys_rst_req}, 32'h0);
    rd(4'd1, d); chk("R8 lockup disabled no cause", d, 32'h0);
    wr(4'd0, 32'h12A);
    pulse(2);
    chk("R8 lockup enabled requests", {31'h0, sys_rst_req}, 32'h1);
    rd(4'd1, d); chk("R8 lockup cause bit 3", d, 32'h08);
    wr(4'd1, 32'h08);
  endtask

  task automatic t_core_cmd();
    logic [31:0] d;
    wr(4'd0, 32'h32A);
    chk("R9 core request raised", {31'h0, core_rst_req}, 32'h1);
    rd(4'd0, d); chk("R9 command reads 1", d, 32'h32A);
    repeat (3) @(negedge clk);
    wr(4'd0, 32'h12A);
    chk("R9 writing 0 ignored", {31'h0, core_rst_req}, 32'h1);
    @(negedge clk); core_rst_done = 1'b1;
    @(negedge clk); core_rst_done = 1'b0;
    chk("R9 cleared after done", {31'h0, core_rst_req}, 32'h0);
    rd(4'd0, d); chk("R9 command reads 0", d, 32'h12A);
  endtask

  task automatic t_periph();
    wr(4'd0, 32'h52A);
    chk("R10 peripheral reset on", {31'h0, periph_rst}, 32'h1);
    repeat (5) @(negedge clk);
    core_rst_done = 1'b1;
    @(negedge clk); core_rst_done = 1'b0;
    chk("R10 peripheral reset held", {31'h0, periph_rst}, 32'h1);
    wr(4'd0, 32'h12A);
    chk("R10 peripheral reset off", {31'h0, periph_rst}, 32'h0);
  endtask

  task automatic t_retention();
    logic [31:0] d;
    wr(4'd2, 32'hDEADBEEF);
    wr(4'd5, 32'h12345678);
    pulse(3);
    wr(4'd0, 32'h75F);
    warm_reset();
    rd(4'd2, d); chk("R11 first word kept", d, 32'hDEADBEEF);
    rd(4'd5, d); chk("R11 last word kept", d, 32'h12345678);
    rd(4'd1, d); chk("R11 cause kept", d, 32'h10);
    rd(4'd0, d); chk("R11 control restored", d, 32'h12A);
    chk("R11 outputs cleared", {29'h0, sys_rst_req, core_rst_req, periph_rst}, 32'h0);
    rd(4'd6, d); chk("R11 unmapped reads zero", d, 32'h0);
    cold_reset();
    rd(4'd2, d); chk("R1 cold reset clears word", d, 32'h0);
    rd(4'd1, d); chk("R1 cold reset cause", d, 32'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    src_event = '0; temp_irq = 1'b0; core_rst_done = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_cause_w1c();
    t_warm_boot();
    t_temp_block();
    t_wdog_mask();
    t_key_codes();
    t_lockup();
    t_core_cmd();
    t_periph();
    t_retention();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule